// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

The block is a programmable countdown timer that asks for a local interrupt when its count runs out. Software sets it up through a small register write port. A 32-bit control entry holds the interrupt vector, the delivery mode, the trigger mode, a mask bit and a periodic flag. An initial-count register arms the countdown. A divide register slows the count clock by a power of two between 1 and 128.

When the count steps from 1 to 0, the block reads the control entry. If the mask bit is clear, it raises `req_valid` for one clock cycle. During that cycle the request fields carry the vector, the delivery mode and the trigger mode. Then one of two things happens:
- With the periodic flag set, the counter reloads from the initial count and keeps running, whether or not the mask bit is set.
- With the flag clear, the counter stops at zero.

A registered read port returns the control entry, the initial count, the remaining count and the divide setting.

Top module: `lvt_timer`

## Requirements
- R1: After a synchronous reset:
  - every register reads as zero;
  - `req_valid` is low;
  - the timer is idle, and without a new initial-count write it produces no request.
- R2: A write of a nonzero value N to address 1 (initial count) loads the counter with N and starts it. With divide code d, the counter then falls by one every 2^d clock cycles. The first decrement comes 2^d clock edges after the write edge, so the expiry falls N·2^d edges after it.
- R3: `req_valid` is high for the one cycle that follows the clock edge at which the count steps from 1 to 0, and only if bit 16 (mask) of the control entry was clear at that edge. A masked expiry gives no request.
- R4: If bit 17 (periodic) of the control entry is set, the counter reloads from the initial-count register at expiry and counts on, giving one expiry every N·2^d cycles. This holds whether the entry is masked or not.
- R5: If bit 17 is clear, the counter stays at 0 after its expiry, and no further request follows until the next nonzero initial-count write.
- R6: A request carries the following fields of the control entry as it stood at the expiry edge:
  - bits 7:0 on `req_vector`;
  - bits 10:8 on `req_mode`;
  - bit 15 on `req_level`.
- R7: Writing the initial count while the timer is running restarts the countdown from the new value, and the old countdown yields no request. Writing zero stops the timer at count 0 with no request.
- R8: The read port takes `rd_addr` and returns the register on `rd_data` after the next clock edge:
  - address 0 returns the full 32-bit control entry as written;
  - address 1 returns the initial count;
  - address 2 returns the remaining count;
  - address 3 returns the divide code.
- R9: Bits 2:0 of a write to address 3 give the divide code d (prescale 2^d, from 1 to 128). A write to address 2 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 entry, 1 initial count, 2 none, 3 divide |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map, 2 is remaining count |
| rd_data | output | 32 | Registered read data |
| req_valid | output | 1 | One-cycle interrupt request |
| req_vector | output | 8 | Vector of the request |
| req_mode | output | 3 | Delivery mode of the request |
| req_level | output | 1 | Trigger mode of the request |

## Verification
The bench builds the block with a 16-bit counter and the default 3-bit divide code. This keeps counts short while still reaching the largest prescale of 128, so a full 256-cycle expiry fits in the run. The runs cover several kinds of countdown:
- one-shot countdowns at prescales of 1, 8 and 128;
- a periodic run with three expiries;
- a masked periodic run that is unmasked while counting;
- a restart in mid-count;
- a stop by a zero write.

A scoreboard predicts the exact cycle and the fields of every request from the write times.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;

  localparam int REG_AW = 2;
  localparam int DATA_W = 32;

  typedef enum logic [REG_AW-1:0] {
    A_ENTRY = 2'd0,
    A_INIT  = 2'd1,
    A_CURR  = 2'd2,
    A_DIV   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] mode;
    logic       level;
    logic       masked;
    logic       periodic;
  } entry_t;

  function automatic entry_t decode_entry(input logic [DATA_W-1:0] raw);
    entry_t e;
    e.vector   = raw[7:0];
    e.mode     = raw[10:8];
    e.level    = raw[15];
    e.masked   = raw[16];
    e.periodic = raw[17];
    return e;
  endfunction

endpackage

// File: rtl/lvt_regs.sv
module lvt_regs
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [REG_AW-1:0]     rd_addr,
  input  logic [CNT_W-1:0]      cur_count,
  output logic [DATA_W-1:0]     rd_data,
  output logic [DATA_W-1:0]     entry_raw,
  output logic [CNT_W-1:0]      init_q,
  output logic [DIV_W-1:0]      div_q,
  output logic                  load,
  output logic [CNT_W-1:0]      load_val
);

  logic wr_entry, wr_div;

  always_comb begin
    wr_entry = wr_en && (wr_addr == A_ENTRY);
    load     = wr_en && (wr_addr == A_INIT);
    wr_div   = wr_en && (wr_addr == A_DIV);
    load_val = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_raw <= '0;
      init_q    <= '0;
      div_q     <= '0;
    end else begin
      if (wr_entry) entry_raw <= wr_data;
      if (load)     init_q    <= load_val;
      if (wr_div)   div_q     <= wr_data[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_ENTRY: rd_data <= entry_raw;
        A_INIT:  rd_data <= DATA_W'(init_q);
        A_CURR:  rd_data <= DATA_W'(cur_count);
        default: rd_data <= DATA_W'(div_q);
      endcase
    end
  end

endmodule

// File: rtl/lvt_prescaler.sv
module lvt_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  generate
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = (DIV_W'(i) < div);
    end
  endgenerate

  assign tick = ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/lvt_countdown.sv
module lvt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cur_q,
  output logic             run_q,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_one;
  assign at_one = (cur_q == ONE);
  assign expire = run_q && tick && at_one && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cur_q <= load_val;
      run_q <= |load_val;
    end else if (run_q && tick) begin
      if (at_one) begin
        if (periodic) begin
          cur_q <= reload_val;
        end else begin
          cur_q <= '0;
          run_q <= 1'b0;
        end
      end else begin
        cur_q <= cur_q - ONE;
      end
    end
  end

endmodule

// File: rtl/lvt_request.sv
module lvt_request
  import lvt_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  entry_t     entry,
  output logic       req_valid,
  output logic [7:0] req_vector,
  output logic [2:0] req_mode,
  output logic       req_level
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_vector <= '0;
      req_mode   <= '0;
      req_level  <= 1'b0;
    end else begin
      req_valid <= expire && !entry.masked;
      if (expire) begin
        req_vector <= entry.vector;
        req_mode   <= entry.mode;
        req_level  <= entry.level;
      end
    end
  end

endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        req_valid,
  output logic [7:0]  req_vector,
  output logic [2:0]  req_mode,
  output logic        req_level
);

  logic [DATA_W-1:0] entry_raw;
  logic [CNT_W-1:0]  init_q;
  logic [DIV_W-1:0]  div_q;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  cur_q;
  logic              run_q;
  logic              expire;
  logic              tick;
  entry_t            entry;

  assign entry = decode_entry(entry_raw);

  lvt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cur_count(cur_q), .rd_data(rd_data),
    .entry_raw(entry_raw), .init_q(init_q), .div_q(div_q),
    .load(load), .load_val(load_val)
  );

  lvt_prescaler #(.DIV_W(DIV_W)) i_pre (
    .clk(clk), .rst(rst), .restart(load), .div(div_q), .tick(tick)
  );

  lvt_countdown #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .reload_val(init_q), .periodic(entry.periodic), .tick(tick),
    .cur_q(cur_q), .run_q(run_q), .expire(expire)
  );

  lvt_request i_req (
    .clk(clk), .rst(rst), .expire(expire), .entry(entry),
    .req_valid(req_valid), .req_vector(req_vector),
    .req_mode(req_mode), .req_level(req_level)
  );

endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [7:0]       req_vector,
  input logic [2:0]       req_mode,
  input logic             req_level,
  input logic [31:0]      entry_raw,
  input logic [CNT_W-1:0] init_q,
  input logic [CNT_W-1:0] cur_q,
  input logic             run_q,
  input logic             load
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R3: a request follows only an unmasked entry
  p_mask_gates_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && req_valid) |-> !$past(entry_raw[16]));

  // R4 and R5: after a request the count is reloaded or parked at zero
  p_reload_or_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && req_valid) |->
      (cur_q == ($past(entry_raw[17]) ? $past(init_q) : '0)));

  // R5: an idle counter holds its value until loaded
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(run_q) && !$past(load)) |-> (cur_q == $past(cur_q)));

  // R2: a running count steps down by at most one per cycle
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(run_q) && !$past(load) && ($past(cur_q) != CNT_W'(1)))
      |-> ((cur_q == $past(cur_q)) || (cur_q == $past(cur_q) - CNT_W'(1))));

  // R6: request fields come from the entry at the expiry edge
  p_fields_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && req_valid) |->
      ((req_vector == $past(entry_raw[7:0])) && (req_mode == $past(entry_raw[10:8]))
       && (req_level == $past(entry_raw[15]))));

endmodule

bind lvt_timer lvt_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vector(req_vector),
  .req_mode(req_mode), .req_level(req_level), .entry_raw(entry_raw),
  .init_q(init_q), .cur_q(cur_q), .run_q(run_q), .load(load)
);

// File: tb/test_lvt_timer.sv
module test_lvt_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        req_valid;
  logic [7:0]  req_vector;
  logic [2:0]  req_mode;
  logic        req_level;

  lvt_timer #(.CNT_W(CNT_W), .DIV_W(3)) i_lvt_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_valid(req_valid),
    .req_vector(req_vector), .req_mode(req_mode), .req_level(req_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int unsigned cyc;
    logic [7:0]  vec;
    logic [2:0]  mode;
    logic        lvl;
  } exp_t;

  exp_t        sb[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  int unsigned last_ld = 0;
  int unsigned t;
  logic [31:0] v;
  logic [7:0]  cur_vec;
  logic [2:0]  cur_mode;
  logic        cur_lvl;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every request
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3: actual unexpected request at cycle %0d expected none", cyc);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R2 request cycle", cyc, e.cyc);
        chk("R6 vector", {24'd0, req_vector}, {24'd0, e.vec});
        chk("R6 mode", {29'd0, req_mode}, {29'd0, e.mode});
        chk("R6 trigger", {31'd0, req_level}, {31'd0, e.lvl});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    last_ld = cyc;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] val, output int unsigned tt);
    @(negedge clk);
    tt = cyc; rd_addr = a;
    @(posedge clk); #1;
    val = rd_data;
  endtask

  task automatic set_entry(input logic [7:0] vec, input logic [2:0] mode, input logic lvl,
                           input logic msk, input logic per);
    cur_vec = vec; cur_mode = mode; cur_lvl = lvl;
    wr(2'd0, {14'd0, per, msk, lvl, 4'd0, mode, vec});
  endtask

  task automatic push(input int unsigned c);
    exp_t e;
    e.cyc = c; e.vec = cur_vec; e.mode = cur_mode; e.lvl = cur_lvl;
    sb.push_back(e);
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (sb.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    chk(req, sb.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned L, w, nxt;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v, t);
      chk("R1 reset register", v, 0);
    end
    chk("R1 request low", {31'd0, req_valid}, 0);
    repeat (20) @(negedge clk);

    // R8 readback of the full entry including unused bits
    wr(2'd0, 32'h0003_7241);
    rd(2'd0, v, t);
    chk("R8 entry readback", v, 32'h0003_7241);

    // one-shot, prescale 1
    set_entry(8'h41, 3'd2, 1'b1, 1'b0, 1'b0);
    wr(2'd3, 0);
    wr(2'd1, 5); L = last_ld; push(L + 5);
    rd(2'd1, v, t);
    chk("R8 init readback", v, 5);
    wait_until(L + 20);
    drain("R3 one-shot request seen");
    rd(2'd2, v, t);
    chk("R5 one-shot parks at zero", v, 0);

    // one-shot, prescale 8
    set_entry(8'h7e, 3'd5, 1'b0, 1'b0, 1'b0);
    wr(2'd3, 3);
    wr(2'd1, 4); L = last_ld; push(L + 32);
    repeat (8) @(negedge clk);
    rd(2'd2, v, t);
    chk("R2 count under prescale 8", v, 4 - (t - L) / 8);
    rd(2'd3, v, t);
    chk("R9 divide readback", v, 3);
    wait_until(L + 45);
    drain("R9 prescale 8 request seen");

    // one-shot, prescale 128
    set_entry(8'hc3, 3'd7, 1'b1, 1'b0, 1'b0);
    wr(2'd3, 7);
    wr(2'd1, 2); L = last_ld; push(L + 256);
    wait_until(L + 270);
    drain("R9 prescale 128 request seen");

    // periodic, three expiries
    wr(2'd3, 0);
    set_entry(8'h90, 3'd0, 1'b0, 1'b0, 1'b1);
    wr(2'd1, 6); L = last_ld;
    push(L + 6); push(L + 12); push(L + 18);
    wait_until(L + 8);
    rd(2'd2, v, t);
    chk("R4 periodic count after reload", v, 6 - ((t - L) % 6));
    wait_until(L + 20);
    wr(2'd1, 0);
    drain("R4 periodic requests seen");
    repeat (15) @(negedge clk);
    rd(2'd2, v, t);
    chk("R7 zero write stops periodic", v, 0);

    // masked periodic keeps reloading, then unmask
    set_entry(8'h22, 3'd1, 1'b1, 1'b1, 1'b1);
    wr(2'd1, 4); L = last_ld;
    wait_until(L + 10);
    rd(2'd2, v, t);
    chk("R4 masked reload continues", v, 4 - ((t - L) % 4) + (((t - L) % 4 == 0) ? 0 : 0));
    set_entry(8'h23, 3'd1, 1'b1, 1'b0, 1'b1);
    w = last_ld;
    nxt = L + 4 * ((w - L) / 4 + 1);
    push(nxt);
    drain("R3 request after unmask");
    wr(2'd1, 0);
    repeat (10) @(negedge clk);

    // restart in mid-count
    set_entry(8'h5a, 3'd4, 1'b0, 1'b0, 1'b0);
    wr(2'd1, 10);
    repeat (3) @(negedge clk);
    wr(2'd1, 3); L = last_ld; push(L + 3);
    wait_until(L + 25);
    drain("R7 restarted request seen");

    // zero write stops a running one-shot
    wr(2'd1, 8);
    repeat (3) @(negedge clk);
    wr(2'd1, 0);
    repeat (15) @(negedge clk);
    rd(2'd2, v, t);
    chk("R7 zero write stops count", v, 0);

    // write to the count address is ignored
    wr(2'd2, 32'h55);
    rd(2'd2, v, t);
    chk("R9 count address write ignored", v, 0);
    rd(2'd1, v, t);
    chk("R9 init unchanged", v, 0);
    repeat (5) @(negedge clk);
    chk("R1 no stray requests pending", sb.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule